// File: doc/BRIEF.md
# AES Encrypt Half-Round Unit

This unit carries out a partial AES encryption step on a 128-bit block. It takes a state operand and a round-key operand, XORs them, rotates the rows of the combined block and passes every byte through the AES forward substitution box. The 128-bit result comes back on the output channel as the new state. The unit does not do the column-mixing step, so a full middle round is built by following this unit with a separate column-mix stage.

The step order is key addition, then row rotation, then byte substitution. A textbook AES round orders these differently, and the ordering here suits chained single-step use. Both sides use a valid/ready handshake. One register stage lies between an accepted input and its result. No path depends on the data, so the latency is the same for every operand value.

The state is column-major. Byte i occupies bits [8i+7:8i], and bytes 4c to 4c+3 form column c, with row index r = i mod 4.

Top module: `aes_enc_half_round`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `res_valid` is 0 and `op_ready` is 1.
- R2: The first operation is a bitwise XOR of `op_state` and `op_key`. When both operands are equal, every result byte is 0x63.
- R3: After the XOR, row r (bytes with index mod 4 equal to r) rotates left by r columns. Result byte 4c+r takes the XOR byte 4((c+r) mod 4)+r.
- R4: The AES forward S-box is applied last to each byte, for example 0x00 to 0x63, 0x01 to 0x7C and 0x53 to 0xED. Its output is `res_state`.
- R5: An input accepted at a clock edge (`op_valid` and `op_ready` both 1) gives `res_valid` = 1 with its result from that edge until the result is taken.
- R6: While `res_valid` is 1 and `res_ready` is 0, `res_state` and `res_valid` hold, and `op_ready` is 0, so no new input is taken.
- R7: When `res_ready` is 1, `op_ready` is 1. A new input can be accepted every cycle, and results come out in order.
- R8: The latency from acceptance to result is one cycle for every operand value, including all-zero and all-ones operands.
- R9: When a result is taken and no new input is accepted at the same edge, `res_valid` goes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operands are presented |
| op_ready | output | 1 | Unit can accept operands |
| op_state | input | 128 | State operand, byte i at bits [8i+7:8i] |
| op_key | input | 128 | Round-key operand, same byte layout |
| res_valid | output | 1 | Result is available |
| res_ready | input | 1 | Consumer takes the result |
| res_state | output | 128 | Result state, same byte layout |

## Verification
The standard round-one vector, with the key XOR, row rotation and substitution outputs known, checks the full step order. If the rotation or substitution were misplaced, the result bytes would land in the wrong positions. Equal operands and a zero key with single-byte states isolate the S-box from the permutation. Each marked byte shows whether it reached the correct destination column. Randomly drawn operands, streamed back-to-back and mixed with all-zero and all-ones blocks, are compared with a bench model, and they show that throughput and latency do not change with the data. A stall with a waiting second input shows that the result holds and the waiting input is not taken early.

// File: rtl/aes_hr_pkg.sv
package aes_hr_pkg;
  localparam int BYTE_W    = 8;
  localparam int NUM_ROWS  = 4;
  localparam int NUM_COLS  = 4;
  localparam int NUM_BYTES = NUM_ROWS * NUM_COLS;
  localparam int STATE_W   = NUM_BYTES * BYTE_W;

  localparam logic [BYTE_W-1:0] GF_POLY    = 8'h1B;
  localparam logic [BYTE_W-1:0] AFFINE_C   = 8'h63;

  typedef logic [BYTE_W-1:0]  byte_t;
  typedef logic [STATE_W-1:0] state_t;

  // Multiply two field elements modulo the AES polynomial.
  function automatic byte_t gf_mul(input byte_t a, input byte_t b);
    byte_t acc;
    byte_t sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = {sh[BYTE_W-2:0], 1'b0} ^ (sh[BYTE_W-1] ? GF_POLY : 8'h00);
    end
    return acc;
  endfunction

  // Inverse as x^254: product of x^2, x^4, ..., x^128 (zero maps to zero).
  function automatic byte_t gf_inv(input byte_t x);
    byte_t pw;
    byte_t prod;
    pw   = x;
    prod = 8'h01;
    for (int i = 1; i < BYTE_W; i++) begin
      pw   = gf_mul(pw, pw);
      prod = gf_mul(prod, pw);
    end
    return prod;
  endfunction

  function automatic byte_t rotl8(input byte_t v, input int n);
    return byte_t'((v << n) | (v >> (BYTE_W - n)));
  endfunction

  function automatic byte_t sbox_affine(input byte_t v);
    return v ^ rotl8(v, 1) ^ rotl8(v, 2) ^ rotl8(v, 3) ^ rotl8(v, 4) ^ AFFINE_C;
  endfunction
endpackage

// File: rtl/aes_hr_keymix_shift.sv
module aes_hr_keymix_shift
  import aes_hr_pkg::*;
(
  input  logic [STATE_W-1:0] state_i,
  input  logic [STATE_W-1:0] key_i,
  output logic [STATE_W-1:0] shifted_o
);
  logic [STATE_W-1:0] mixed;

  assign mixed = state_i ^ key_i;

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
      localparam int DST = c * NUM_ROWS + r;
      localparam int SRC = ((c + r) % NUM_COLS) * NUM_ROWS + r;
      assign shifted_o[DST*BYTE_W +: BYTE_W] = mixed[SRC*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/aes_hr_sbox.sv
module aes_hr_sbox
  import aes_hr_pkg::*;
(
  input  logic [BYTE_W-1:0] in_byte,
  output logic [BYTE_W-1:0] out_byte
);
  byte_t inv;

  always_comb begin
    inv      = gf_inv(in_byte);
    out_byte = sbox_affine(inv);
  end
endmodule

// File: rtl/aes_hr_sub_layer.sv
module aes_hr_sub_layer
  import aes_hr_pkg::*;
(
  input  logic [STATE_W-1:0] blk_i,
  output logic [STATE_W-1:0] blk_o
);
  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_sb
    aes_hr_sbox u_sbox (
      .in_byte  (blk_i[b*BYTE_W +: BYTE_W]),
      .out_byte (blk_o[b*BYTE_W +: BYTE_W])
    );
  end
endmodule

// File: rtl/aes_hr_out_stage.sv
module aes_hr_out_stage
  import aes_hr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               up_valid,
  output logic               up_ready,
  input  logic [STATE_W-1:0] up_data,
  output logic               dn_valid,
  input  logic               dn_ready,
  output logic [STATE_W-1:0] dn_data
);
  logic               vld_q, vld_d;
  logic [STATE_W-1:0] dat_q;
  logic               load_en;

  always_comb begin
    up_ready = !vld_q || dn_ready;
    load_en  = up_valid && up_ready;
    if (load_en)       vld_d = 1'b1;
    else if (dn_ready) vld_d = 1'b0;
    else               vld_d = vld_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dat_q <= '0;
    else if (load_en) dat_q <= up_data;
  end

  assign dn_valid = vld_q;
  assign dn_data  = dat_q;
endmodule

// File: rtl/aes_enc_half_round.sv
module aes_enc_half_round
  import aes_hr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               op_valid,
  output logic               op_ready,
  input  logic [STATE_W-1:0] op_state,
  input  logic [STATE_W-1:0] op_key,
  output logic               res_valid,
  input  logic               res_ready,
  output logic [STATE_W-1:0] res_state
);
  logic [STATE_W-1:0] shifted;
  logic [STATE_W-1:0] substituted;

  aes_hr_keymix_shift u_mix (
    .state_i   (op_state),
    .key_i     (op_key),
    .shifted_o (shifted)
  );

  aes_hr_sub_layer u_sub (
    .blk_i (shifted),
    .blk_o (substituted)
  );

  aes_hr_out_stage u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (op_valid),
    .up_ready (op_ready),
    .up_data  (substituted),
    .dn_valid (res_valid),
    .dn_ready (res_ready),
    .dn_data  (res_state)
  );
endmodule

// File: rtl/aes_hr_checker.sv
module aes_hr_checker
  import aes_hr_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               op_valid,
  input logic               op_ready,
  input logic [STATE_W-1:0] op_state,
  input logic [STATE_W-1:0] op_key,
  input logic               res_valid,
  input logic               res_ready,
  input logic [STATE_W-1:0] res_state
);
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!res_valid && op_ready));

  assert_equal_ops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && (op_state == op_key)) |=> (res_state == {NUM_BYTES{AFFINE_C}}));

  assert_accept_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready) |=> res_valid);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_state)));

  assert_stall_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |-> !op_ready);

  assert_ready_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_ready |-> op_ready);

  assert_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready && !op_valid) |=> !res_valid);
endmodule

bind aes_enc_half_round aes_hr_checker u_chk (.*);

// File: tb/aes_enc_half_round_bench.sv
module aes_enc_half_round_bench;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         op_valid, op_ready, res_valid, res_ready;
  logic [127:0] op_state, op_key, res_state;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  logic [7:0] sb [256];

  always #10 clk = ~clk;

  aes_enc_half_round u_aes_enc_half_round (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_state(op_state), .op_key(op_key), .res_valid(res_valid),
    .res_ready(res_ready), .res_state(res_state)
  );

  // S-box table built by the generator walk over the multiplicative group.
  task automatic build_sbox();
    logic [7:0] p, q, x;
    p = 8'h01; q = 8'h01;
    do begin
      p = p ^ {p[6:0], 1'b0} ^ (p[7] ? 8'h1B : 8'h00);
      q = q ^ {q[6:0], 1'b0};
      q = q ^ {q[5:0], 2'b00};
      q = q ^ {q[3:0], 4'h0};
      if (q[7]) q = q ^ 8'h09;
      x = q ^ {q[6:0], q[7]} ^ {q[5:0], q[7:6]} ^ {q[4:0], q[7:5]} ^ {q[3:0], q[7:4]};
      sb[p] = x ^ 8'h63;
    end while (p != 8'h01);
    sb[0] = 8'h63;
  endtask

  function automatic logic [127:0] model(input logic [127:0] s, input logic [127:0] k);
    logic [127:0] x, o;
    x = s ^ k;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        o[(4*c+r)*8 +: 8] = sb[x[(4*((c+r)%4)+r)*8 +: 8]];
    return o;
  endfunction

  // Listed order (first byte first) to bit layout (byte 0 at bits [7:0]).
  function automatic logic [127:0] lst(input logic [127:0] v);
    logic [127:0] o;
    for (int i = 0; i < 16; i++) o[i*8 +: 8] = v[(15-i)*8 +: 8];
    return o;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Single transfer with the consumer ready; result checked one cycle later.
  task automatic one_shot(input logic [127:0] s, input logic [127:0] k, input string req);
    @(negedge clk);
    op_valid = 1'b1; op_state = s; op_key = k;
    chk(op_ready, "R7 ready before send", {127'd0, op_ready}, 128'd1);
    @(negedge clk);
    op_valid = 1'b0;
    chk(res_valid, "R5 valid one cycle after accept", {127'd0, res_valid}, 128'd1);
    chk(res_state == model(s, k), req, res_state, model(s, k));
    @(negedge clk);
    chk(!res_valid, "R9 drained", {127'd0, res_valid}, 128'd0);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [127:0] a_s, a_k, b_s, b_k, prev_s, prev_k, pin, exp;
    logic [127:0] mark;
    void'($urandom(32'd20240611));
    build_sbox();
    rst_n = 1'b0; op_valid = 1'b0; res_ready = 1'b1; op_state = '0; op_key = '0;
    #1;
    chk(!res_valid && op_ready, "R1 in reset", {126'd0, res_valid, op_ready}, 128'd1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!res_valid && op_ready, "R1 after reset", {126'd0, res_valid, op_ready}, 128'd1);

    // Standard round-one vector: known literal result.
    a_s = lst(128'h3243f6a8885a308d313198a2e0370734);
    a_k = lst(128'h2b7e151628aed2a6abf7158809cf4f3c);
    exp = lst(128'hd4bf5d30e0b452aeb84111f11e2798e5);
    chk(model(a_s, a_k) == exp, "R2 R3 R4 bench model vector", model(a_s, a_k), exp);
    one_shot(a_s, a_k, "R2 R3 R4 round vector");
    chk(res_state == exp, "R2 R3 R4 literal", res_state, exp);

    // Equal operands: all bytes 0x63.
    pin = rnd128();
    one_shot(pin, pin, "R2 equal operands");
    chk(res_state == {16{8'h63}}, "R2 R4 all 0x63", res_state, {16{8'h63}});

    // Single-byte S-box values with zero key, row 0 byte stays in place.
    one_shot(128'h01, 128'h0, "R4 byte 0x01");
    chk(res_state[7:0] == 8'h7C, "R4 0x01 to 0x7C", {120'd0, res_state[7:0]}, 128'h7C);
    one_shot(128'h53, 128'h0, "R4 byte 0x53");
    chk(res_state[7:0] == 8'hED, "R4 0x53 to 0xED", {120'd0, res_state[7:0]}, 128'hED);

    // Row rotation: mark each position in turn, find where it lands.
    for (int i = 0; i < 16; i++) begin
      int r, c, d;
      mark = '0;
      mark[i*8 +: 8] = 8'h53;
      r = i % 4; c = i / 4;
      d = 4 * ((c - r + 4) % 4) + r;
      one_shot(mark, 128'h0, "R3 marked byte");
      chk(res_state[d*8 +: 8] == 8'hED, "R3 destination byte",
          {120'd0, res_state[d*8 +: 8]}, 128'hED);
    end

    // Back-to-back stream with corner blocks and random blocks.
    @(negedge clk);
    for (int n = 0; n < 300; n++) begin
      logic [127:0] s, k;
      case (n % 50)
        0: begin s = '0; k = '0; end
        1: begin s = '1; k = '0; end
        2: begin s = '0; k = '1; end
        default: begin s = rnd128(); k = rnd128(); end
      endcase
      op_valid = 1'b1; op_state = s; op_key = k;
      if (n > 0) begin
        chk(res_valid, "R8 fixed latency stream", {127'd0, res_valid}, 128'd1);
        chk(res_state == model(prev_s, prev_k), "R7 R8 stream data",
            res_state, model(prev_s, prev_k));
      end
      chk(op_ready, "R7 ready each cycle", {127'd0, op_ready}, 128'd1);
      prev_s = s; prev_k = k;
      @(negedge clk);
    end
    op_valid = 1'b0;
    chk(res_state == model(prev_s, prev_k), "R7 last stream data", res_state, model(prev_s, prev_k));
    @(negedge clk);
    chk(!res_valid, "R9 drained after stream", {127'd0, res_valid}, 128'd0);

    // Backpressure: result holds, waiting input not taken.
    a_s = rnd128(); a_k = rnd128(); b_s = rnd128(); b_k = rnd128();
    res_ready = 1'b0;
    op_valid = 1'b1; op_state = a_s; op_key = a_k;
    @(negedge clk);
    op_state = b_s; op_key = b_k;
    for (int w = 0; w < 4; w++) begin
      chk(res_valid && res_state == model(a_s, a_k), "R6 result held",
          res_state, model(a_s, a_k));
      chk(!op_ready, "R6 input blocked", {127'd0, op_ready}, 128'd0);
      @(negedge clk);
    end
    res_ready = 1'b1;
    #1;
    chk(op_ready, "R7 ready follows consumer", {127'd0, op_ready}, 128'd1);
    @(negedge clk);
    op_valid = 1'b0;
    chk(res_valid && res_state == model(b_s, b_k), "R6 waiting input after release",
        res_state, model(b_s, b_k));
    @(negedge clk);
    chk(!res_valid, "R9 drained after stall", {127'd0, res_valid}, 128'd0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule